// File: doc/BRIEF.md
# Power-Management Event and System-Interrupt Controller

This block holds the fixed power-management register set of a chip and sits on a simple I/O port bus. It has a 16-bit event status register and a 16-bit event enable register, one address apart by two. It also has a 16-bit power control register, byte-wide general-purpose event status and enable registers, and a write-only command port. The command port switches the power-management mode on and off. A hardware power-button pulse and a general-purpose raise vector set status flags. Software clears those flags by writing ones.

The block combines every enabled-and-pending pair into one level-sensitive system control interrupt, `ctl_irq`. A control write that selects sleep type 5 and also sets the sleep-enable bit produces a one-cycle soft-power-off request, `soff_req`. Bus accesses are single-cycle. A write takes effect at the clock edge that samples it. A read returns data combinationally. An access with the wrong byte count is refused: `io_err` is raised and no register changes.

Top module: `acpi_pm_sci`

## Requirements
- R1: Access size rules. `io_size` holds the byte count. The event status, event enable and control registers need 2. The general-purpose status, general-purpose enable and command port need 1. Any other size on a decoded address raises `io_err` in that cycle, and the access changes nothing. A read of the command port also raises `io_err`. The default addresses are: status 0x0400, enable 0x0402, control 0x0404, general-purpose status 0x0408, general-purpose enable 0x0409, command 0x00B2.
- R2: A write to the event enable register stores only bits 0x0400, 0x0100 and 0x0020. Every other bit is stored as 0.
- R3: A power-button pulse sets event status bit 0x0100. A button pulse wins over a clear of that bit in the same cycle.
- R4: Writing 1 to an event status bit clears it only for bits 0x8000, 0x0400, 0x0200, 0x0100 and 0x0010. Ones in every other position have no effect.
- R5: `ctl_irq` is high when status and enable share a set bit among 0x0001, 0x0020, 0x0100, 0x0200 and 0x0400, or when the general-purpose status and enable registers share any set bit. Otherwise it is low. It changes one clock after the registers change.
- R6: A control write keeps bit 0 (mode) at its previous value. It stores bits 15, 14, 13 and 1 as 0. Every other bit takes the written data.
- R7: `soff_req` pulses for one cycle after a control write whose bit 13 is 1 and whose bits 12:10 equal 5. No other write produces the pulse.
- R8: A general-purpose raise sets status bits, masked to the valid mask (default 0x0F). A write clears the status bits it has ones in, again masked. A raise wins over a clear of the same bit in the same cycle.
- R9: A general-purpose enable write stores the written byte masked to the valid mask.
- R10: Command byte 0xA0 sets control bit 0 and command byte 0xA1 clears it. Any other byte changes nothing.
- R11: After reset every register reads 0 and both `ctl_irq` and `soff_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 16 | Port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_size | input | 2 | Access byte count |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, combinational, 0 when not reading a valid register |
| io_err | output | 1 | Refused access (wrong size, or a read of the command port) |
| pwr_btn | input | 1 | Power-button event pulse |
| gp_raise | input | 8 | General-purpose event raise bits |
| ctl_irq | output | 1 | Level system control interrupt |
| soff_req | output | 1 | Soft-power-off request pulse |

## Verification
Some behaviours are checked by assertions on every cycle. `ctl_irq` must track the enabled-and-pending state one clock late. Enable and control writes must store only their permitted bits. Refused writes must leave the registers untouched. Every `soff_req` pulse must trace back to a qualifying control write. The directed scenarios show the rest: the exact clear masks, set-wins ordering when a button pulse or raise meets a clear in the same cycle, command-code decoding including ignored codes, and interrupt gating as enables come and go.

// File: rtl/acpi_pm_pkg.sv
package acpi_pm_pkg;
  localparam int unsigned REG_W = 16;

  // event status / enable bit positions (decoded by system software)
  localparam logic [REG_W-1:0] EV_TMR = 16'h0001;
  localparam logic [REG_W-1:0] EV_BM  = 16'h0010;
  localparam logic [REG_W-1:0] EV_GBL = 16'h0020;
  localparam logic [REG_W-1:0] EV_PWR = 16'h0100;
  localparam logic [REG_W-1:0] EV_SLP = 16'h0200;
  localparam logic [REG_W-1:0] EV_RTC = 16'h0400;
  localparam logic [REG_W-1:0] EV_WAK = 16'h8000;

  localparam logic [REG_W-1:0] EV_CLR_MASK = EV_WAK | EV_RTC | EV_SLP | EV_PWR | EV_BM;
  localparam logic [REG_W-1:0] EN_KEEP     = EV_RTC | EV_PWR | EV_GBL;
  localparam logic [REG_W-1:0] IRQ_PAIRS   = EV_TMR | EV_GBL | EV_PWR | EV_SLP | EV_RTC;

  // power control register layout
  localparam int unsigned      CTL_MODE_BIT  = 0;
  localparam int unsigned      CTL_SLPEN_BIT = 13;
  localparam int unsigned      CTL_TYPE_LSB  = 10;
  localparam logic [REG_W-1:0] CTL_FORCE0    = 16'hE003;
  localparam logic [2:0]       SOFTOFF_TYPE  = 3'd5;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STS, SEL_EN, SEL_CTL, SEL_GSTS, SEL_GEN, SEL_CMD
  } reg_sel_e;

  typedef struct packed {
    logic sts_we;
    logic en_we;
    logic ctl_we;
    logic gsts_we;
    logic gen_we;
    logic cmd_we;
  } wr_strb_t;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/pm_io_decode.sv
module pm_io_decode
  import acpi_pm_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] EVT_BASE    = 16'h0400,
  parameter logic [ADDR_W-1:0] CTL_ADDR    = 16'h0404,
  parameter logic [ADDR_W-1:0] GP_STS_ADDR = 16'h0408,
  parameter logic [ADDR_W-1:0] GP_EN_ADDR  = 16'h0409,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 16'h00B2
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [1:0]        io_size,
  output reg_sel_e          sel,
  output wr_strb_t          strb,
  output logic              rd_ok,
  output logic              io_err
);
  localparam logic [ADDR_W-1:0] EN_ADDR = EVT_BASE + ADDR_W'(2);

  logic [1:0] need;
  logic       bad;
  logic       wr_go;

  always_comb begin
    if (io_addr == EVT_BASE)         sel = SEL_STS;
    else if (io_addr == EN_ADDR)     sel = SEL_EN;
    else if (io_addr == CTL_ADDR)    sel = SEL_CTL;
    else if (io_addr == GP_STS_ADDR) sel = SEL_GSTS;
    else if (io_addr == GP_EN_ADDR)  sel = SEL_GEN;
    else if (io_addr == CMD_ADDR)    sel = SEL_CMD;
    else                             sel = SEL_NONE;

    case (sel)
      SEL_STS, SEL_EN, SEL_CTL:   need = 2'd2;
      SEL_GSTS, SEL_GEN, SEL_CMD: need = 2'd1;
      default:                    need = 2'd0;
    endcase

    bad    = (sel != SEL_NONE) && ((io_size != need) || (sel == SEL_CMD && io_rd));
    io_err = (io_wr | io_rd) && bad;
    wr_go  = io_wr && (sel != SEL_NONE) && !bad;
    rd_ok  = io_rd && (sel != SEL_NONE) && !bad;

    strb.sts_we  = wr_go && (sel == SEL_STS);
    strb.en_we   = wr_go && (sel == SEL_EN);
    strb.ctl_we  = wr_go && (sel == SEL_CTL);
    strb.gsts_we = wr_go && (sel == SEL_GSTS);
    strb.gen_we  = wr_go && (sel == SEL_GEN);
    strb.cmd_we  = wr_go && (sel == SEL_CMD);
  end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import acpi_pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sts_we,
  input  logic             en_we,
  input  logic [REG_W-1:0] wdata,
  input  logic             pwr_btn,
  output logic [REG_W-1:0] sts_q,
  output logic [REG_W-1:0] en_q
);
  logic [REG_W-1:0] sts_d, en_d;
  logic             sts_ce;

  always_comb begin
    sts_d = sts_q;
    if (sts_we) sts_d = sts_q & ~(wdata & EV_CLR_MASK);
    // a button press outranks a simultaneous clear
    if (pwr_btn) sts_d = sts_d | EV_PWR;
    sts_ce = sts_we | pwr_btn;
    en_d   = wdata & EN_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      if (sts_ce) sts_q <= sts_d;
      if (en_we)  en_q  <= en_d;
    end
  end
endmodule

// File: rtl/pm_ctl_regs.sv
module pm_ctl_regs
  import acpi_pm_pkg::*;
#(
  parameter logic [7:0] CMD_ON  = 8'hA0,
  parameter logic [7:0] CMD_OFF = 8'hA1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             cmd_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctl_q,
  output logic             soff_q
);
  logic [REG_W-1:0] ctl_d;
  logic             ctl_ce;
  logic             soff_d;

  always_comb begin
    ctl_d  = ctl_q;
    ctl_ce = 1'b0;
    if (ctl_we) begin
      ctl_d = (wdata & ~CTL_FORCE0);
      ctl_d[CTL_MODE_BIT] = ctl_q[CTL_MODE_BIT];
      ctl_ce = 1'b1;
    end else if (cmd_we) begin
      if (wdata[7:0] == CMD_ON) begin
        ctl_d[CTL_MODE_BIT] = 1'b1;
        ctl_ce = 1'b1;
      end else if (wdata[7:0] == CMD_OFF) begin
        ctl_d[CTL_MODE_BIT] = 1'b0;
        ctl_ce = 1'b1;
      end
    end
    soff_d = ctl_we && wdata[CTL_SLPEN_BIT] &&
             (wdata[CTL_TYPE_LSB +: 3] == SOFTOFF_TYPE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      soff_q <= 1'b0;
    end else begin
      if (ctl_ce) ctl_q <= ctl_d;
      soff_q <= soff_d;
    end
  end
endmodule

// File: rtl/pm_gp_regs.sv
module pm_gp_regs #(
  parameter int unsigned     GP_W     = 8,
  parameter logic [GP_W-1:0] GP_VALID = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gsts_we,
  input  logic            gen_we,
  input  logic [GP_W-1:0] wdata,
  input  logic [GP_W-1:0] raise,
  output logic [GP_W-1:0] gsts_q,
  output logic [GP_W-1:0] gen_q
);
  logic [GP_W-1:0] gsts_d, gen_d;
  logic            gsts_ce;

  always_comb begin
    gsts_d = gsts_q;
    if (gsts_we) gsts_d = gsts_q & ~(wdata & GP_VALID);
    // raise outranks a simultaneous clear
    gsts_d  = gsts_d | (raise & GP_VALID);
    gsts_ce = gsts_we | (|raise);
    gen_d   = wdata & GP_VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gsts_q <= '0;
      gen_q  <= '0;
    end else begin
      if (gsts_ce) gsts_q <= gsts_d;
      if (gen_we)  gen_q  <= gen_d;
    end
  end
endmodule

// File: rtl/pm_irq_gen.sv
module pm_irq_gen
  import acpi_pm_pkg::*;
#(
  parameter int unsigned GP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] sts,
  input  logic [REG_W-1:0] en,
  input  logic [GP_W-1:0]  gsts,
  input  logic [GP_W-1:0]  gen,
  output logic             irq_q
);
  logic [REG_W-1:0] fix_hit;
  logic [GP_W-1:0]  gp_hit;
  logic             pend;

  genvar i;
  generate
    for (i = 0; i < REG_W; i++) begin : g_fix
      assign fix_hit[i] = IRQ_PAIRS[i] & sts[i] & en[i];
    end
    for (i = 0; i < GP_W; i++) begin : g_gp
      assign gp_hit[i] = gsts[i] & gen[i];
    end
  endgenerate

  assign pend = (|fix_hit) | (|gp_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend;
  end
endmodule

// File: rtl/acpi_pm_sci.sv
module acpi_pm_sci
  import acpi_pm_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 16,
  parameter int unsigned       GP_W        = 8,
  parameter logic [GP_W-1:0]   GP_VALID    = 8'h0F,
  parameter logic [7:0]        CMD_ON      = 8'hA0,
  parameter logic [7:0]        CMD_OFF     = 8'hA1,
  parameter logic [ADDR_W-1:0] EVT_BASE    = 16'h0400,
  parameter logic [ADDR_W-1:0] CTL_ADDR    = 16'h0404,
  parameter logic [ADDR_W-1:0] GP_STS_ADDR = 16'h0408,
  parameter logic [ADDR_W-1:0] GP_EN_ADDR  = 16'h0409,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 16'h00B2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [1:0]        io_size,
  input  logic [REG_W-1:0]  io_wdata,
  output logic [REG_W-1:0]  io_rdata,
  output logic              io_err,
  input  logic              pwr_btn,
  input  logic [GP_W-1:0]   gp_raise,
  output logic              ctl_irq,
  output logic              soff_req
);
  logic             rst_sync_n;
  reg_sel_e         sel;
  wr_strb_t         strb;
  logic             rd_ok;
  logic [REG_W-1:0] evt_sts, evt_en, ctl;
  logic [GP_W-1:0]  gp_sts, gp_en;

  pm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  pm_io_decode #(
    .ADDR_W(ADDR_W), .EVT_BASE(EVT_BASE), .CTL_ADDR(CTL_ADDR),
    .GP_STS_ADDR(GP_STS_ADDR), .GP_EN_ADDR(GP_EN_ADDR), .CMD_ADDR(CMD_ADDR)
  ) u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_size(io_size),
    .sel(sel), .strb(strb), .rd_ok(rd_ok), .io_err(io_err)
  );

  pm_evt_regs u_evt (
    .clk(clk), .rst_n(rst_sync_n), .sts_we(strb.sts_we), .en_we(strb.en_we),
    .wdata(io_wdata), .pwr_btn(pwr_btn), .sts_q(evt_sts), .en_q(evt_en)
  );

  pm_ctl_regs #(.CMD_ON(CMD_ON), .CMD_OFF(CMD_OFF)) u_ctl (
    .clk(clk), .rst_n(rst_sync_n), .ctl_we(strb.ctl_we), .cmd_we(strb.cmd_we),
    .wdata(io_wdata), .ctl_q(ctl), .soff_q(soff_req)
  );

  pm_gp_regs #(.GP_W(GP_W), .GP_VALID(GP_VALID)) u_gp (
    .clk(clk), .rst_n(rst_sync_n), .gsts_we(strb.gsts_we), .gen_we(strb.gen_we),
    .wdata(io_wdata[GP_W-1:0]), .raise(gp_raise), .gsts_q(gp_sts), .gen_q(gp_en)
  );

  pm_irq_gen #(.GP_W(GP_W)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .sts(evt_sts), .en(evt_en),
    .gsts(gp_sts), .gen(gp_en), .irq_q(ctl_irq)
  );

  always_comb begin
    io_rdata = '0;
    if (rd_ok) begin
      case (sel)
        SEL_STS:  io_rdata = evt_sts;
        SEL_EN:   io_rdata = evt_en;
        SEL_CTL:  io_rdata = ctl;
        SEL_GSTS: io_rdata = REG_W'(gp_sts);
        SEL_GEN:  io_rdata = REG_W'(gp_en);
        default:  io_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/acpi_pm_sci_chk.sv
module acpi_pm_sci_chk
  import acpi_pm_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       GP_W     = 8,
  parameter logic [GP_W-1:0]   GP_VALID = 8'h0F,
  parameter logic [ADDR_W-1:0] EVT_BASE = 16'h0400,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h0404
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic [1:0]        io_size,
  input logic [REG_W-1:0]  io_wdata,
  input logic              io_err,
  input logic              pwr_btn,
  input logic [REG_W-1:0]  evt_sts,
  input logic [REG_W-1:0]  evt_en,
  input logic [REG_W-1:0]  ctl,
  input logic [GP_W-1:0]   gp_sts,
  input logic [GP_W-1:0]   gp_en,
  input logic              ctl_irq,
  input logic              soff_req
);
  logic en_wr, ctl_wr, soff_wr, pend;

  assign en_wr   = io_wr && io_size == 2'd2 && io_addr == EVT_BASE + ADDR_W'(2);
  assign ctl_wr  = io_wr && io_size == 2'd2 && io_addr == CTL_ADDR;
  assign soff_wr = ctl_wr && io_wdata[13] && io_wdata[12:10] == 3'd5;
  assign pend    = (|(evt_sts & evt_en & IRQ_PAIRS)) | (|(gp_sts & gp_en));

  a_r1_refused_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && io_err |=> $stable(evt_en) && $stable(ctl) && $stable(gp_en));

  a_r2_enable_masked: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> evt_en == ($past(io_wdata) & 16'h0520));

  a_r3_button_sets: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_btn |=> evt_sts[8]);

  a_r5_irq_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> ctl_irq);

  a_r5_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> !ctl_irq);

  a_r6_ctl_write_rule: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl[0] == $past(ctl[0])) && ((ctl & 16'hE002) == 16'h0000));

  a_r7_soff_source: assert property (@(posedge clk) disable iff (!rst_n)
    soff_req |-> $past(soff_wr));

  a_r8_gp_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_sts & ~GP_VALID) == '0);
endmodule

bind acpi_pm_sci acpi_pm_sci_chk #(
  .ADDR_W(ADDR_W), .GP_W(GP_W), .GP_VALID(GP_VALID),
  .EVT_BASE(EVT_BASE), .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .io_addr(io_addr), .io_wr(io_wr),
  .io_size(io_size), .io_wdata(io_wdata), .io_err(io_err), .pwr_btn(pwr_btn),
  .evt_sts(evt_sts), .evt_en(evt_en), .ctl(ctl), .gp_sts(gp_sts),
  .gp_en(gp_en), .ctl_irq(ctl_irq), .soff_req(soff_req)
);

// File: tb/sim_acpi_pm_sci.sv
module sim_acpi_pm_sci;
  localparam int PERIOD = 10;
  localparam logic [15:0] A_STS = 16'h0400, A_EN = 16'h0402, A_CTL = 16'h0404;
  localparam logic [15:0] A_GSTS = 16'h0408, A_GEN = 16'h0409, A_CMD = 16'h00B2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr, io_wdata, io_rdata;
  logic        io_wr, io_rd, io_err;
  logic [1:0]  io_size;
  logic        pwr_btn;
  logic [7:0]  gp_raise;
  logic        ctl_irq, soff_req;

  int n_chk = 0;
  int n_bad = 0;
  logic last_err;

  always #(PERIOD/2) clk = ~clk;

  acpi_pm_sci u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_err(io_err),
    .pwr_btn(pwr_btn), .gp_raise(gp_raise), .ctl_irq(ctl_irq), .soff_req(soff_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive at a negedge, register update at the next posedge, return at the following negedge
  task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [15:0] d);
    @(negedge clk);
    io_addr = a; io_size = sz; io_wdata = d; io_wr = 1'b1;
    #1 last_err = io_err;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] sz, output logic [15:0] d);
    @(negedge clk);
    io_addr = a; io_size = sz; io_rd = 1'b1;
    #1 d = io_rdata; last_err = io_err;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [1:0] sz,
                        input logic [15:0] exp);
    logic [15:0] v;
    rd(a, sz, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    rd_chk("R11 status", A_STS, 2, 16'h0000);
    rd_chk("R11 enable", A_EN, 2, 16'h0000);
    rd_chk("R11 control", A_CTL, 2, 16'h0000);
    rd_chk("R11 gp status", A_GSTS, 1, 16'h0000);
    rd_chk("R11 gp enable", A_GEN, 1, 16'h0000);
    chk("R11 irq", {15'd0, ctl_irq}, 16'd0);
    chk("R11 soff", {15'd0, soff_req}, 16'd0);
  endtask

  task automatic t_enable_mask;
    wr(A_EN, 2, 16'hFFFF);
    rd_chk("R2 enable mask", A_EN, 2, 16'h0520);
  endtask

  task automatic t_size_err;
    logic [15:0] v;
    wr(A_EN, 1, 16'h0000);
    chk("R1 err on byte write to enable", {15'd0, last_err}, 16'd1);
    rd_chk("R1 enable unchanged", A_EN, 2, 16'h0520);
    chk("R1 no err on good read", {15'd0, last_err}, 16'd0);
    rd(A_CMD, 1, v);
    chk("R1 err on command read", {15'd0, last_err}, 16'd1);
    rd(A_GSTS, 2, v);
    chk("R1 err on wide gp read", {15'd0, last_err}, 16'd1);
    wr(A_GEN, 2, 16'h00FF);
    rd_chk("R1 gp enable unchanged", A_GEN, 1, 16'h0000);
  endtask

  task automatic t_button;
    @(negedge clk); pwr_btn = 1'b1;
    @(negedge clk); pwr_btn = 1'b0;
    chk("R5 irq one cycle late", {15'd0, ctl_irq}, 16'd0);
    @(negedge clk);
    chk("R5 irq from button pair", {15'd0, ctl_irq}, 16'd1);
    rd_chk("R3 button sets status", A_STS, 2, 16'h0100);
  endtask

  task automatic t_w1c;
    wr(A_STS, 2, 16'hFEFF);
    rd_chk("R4 other ones leave button bit", A_STS, 2, 16'h0100);
    wr(A_STS, 2, 16'h0100);
    rd_chk("R4 button bit cleared", A_STS, 2, 16'h0000);
    chk("R5 irq low after clear", {15'd0, ctl_irq}, 16'd0);
  endtask

  task automatic t_btn_vs_clear;
    @(negedge clk);
    io_addr = A_STS; io_size = 2; io_wdata = 16'h0100; io_wr = 1'b1; pwr_btn = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; pwr_btn = 1'b0;
    rd_chk("R3 button wins over clear", A_STS, 2, 16'h0100);
  endtask

  task automatic t_irq_gate;
    wr(A_EN, 2, 16'h0000);
    @(negedge clk);
    chk("R5 irq off when enable cleared", {15'd0, ctl_irq}, 16'd0);
    wr(A_EN, 2, 16'h0100);
    @(negedge clk);
    chk("R5 irq back with enable", {15'd0, ctl_irq}, 16'd1);
    wr(A_STS, 2, 16'hFFFF);
    @(negedge clk);
    chk("R5 irq off after full clear", {15'd0, ctl_irq}, 16'd0);
  endtask

  task automatic t_gp;
    @(negedge clk); gp_raise = 8'hFF;
    @(negedge clk); gp_raise = 8'h00;
    rd_chk("R8 raise masked to valid", A_GSTS, 1, 16'h000F);
    chk("R5 no irq with gp enable 0", {15'd0, ctl_irq}, 16'd0);
    wr(A_GEN, 1, 16'h00FF);
    rd_chk("R9 gp enable masked", A_GEN, 1, 16'h000F);
    chk("R5 irq from gp pair", {15'd0, ctl_irq}, 16'd1);
    wr(A_GSTS, 1, 16'h0003);
    rd_chk("R8 gp write-one clear", A_GSTS, 1, 16'h000C);
    wr(A_GEN, 1, 16'h0003);
    @(negedge clk);
    chk("R5 no common gp bit", {15'd0, ctl_irq}, 16'd0);
    @(negedge clk);
    io_addr = A_GSTS; io_size = 1; io_wdata = 16'h000C; io_wr = 1'b1; gp_raise = 8'h04;
    @(negedge clk);
    io_wr = 1'b0; gp_raise = 8'h00;
    rd_chk("R8 raise wins over clear", A_GSTS, 1, 16'h0004);
    wr(A_GSTS, 1, 16'h00FF);
    wr(A_GEN, 1, 16'h0000);
  endtask

  task automatic t_ctl;
    wr(A_CTL, 2, 16'hFFFF);
    chk("R7 no soff for type 7", {15'd0, soff_req}, 16'd0);
    rd_chk("R6 control write masks", A_CTL, 2, 16'h1FFC);
  endtask

  task automatic t_cmd;
    wr(A_CMD, 1, 16'h00A0);
    rd_chk("R10 enable command", A_CTL, 2, 16'h1FFD);
    wr(A_CMD, 1, 16'h0055);
    rd_chk("R10 unknown command ignored", A_CTL, 2, 16'h1FFD);
    wr(A_CTL, 2, 16'h0000);
    rd_chk("R6 mode bit kept on write", A_CTL, 2, 16'h0001);
    wr(A_CMD, 1, 16'h00A1);
    rd_chk("R10 disable command", A_CTL, 2, 16'h0000);
  endtask

  task automatic t_soff;
    wr(A_CTL, 2, 16'h3400);
    chk("R7 soff pulse", {15'd0, soff_req}, 16'd1);
    @(negedge clk);
    chk("R7 soff one cycle", {15'd0, soff_req}, 16'd0);
    rd_chk("R6 stored type without enable bit", A_CTL, 2, 16'h1400);
    wr(A_CTL, 2, 16'h1400);
    chk("R7 no soff without enable bit", {15'd0, soff_req}, 16'd0);
    wr(A_CTL, 2, 16'h2C00);
    chk("R7 no soff for type 3", {15'd0, soff_req}, 16'd0);
  endtask

  initial begin
    rst_n = 1'b0; io_addr = '0; io_wdata = '0; io_wr = 1'b0; io_rd = 1'b0;
    io_size = '0; pwr_btn = 1'b0; gp_raise = '0; last_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable_mask();
    t_size_err();
    t_button();
    t_w1c();
    t_btn_vs_clear();
    t_irq_gate();
    t_gp();
    t_ctl();
    t_cmd();
    t_soff();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule